// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block extends a program sequencer so that counted loops cost no branch cycles. It owns the fetch address register. With no loop running, the fetch address steps by one on every clock. A loop command carries a kind, a first address, a last address and a 16-bit iteration count. On a command the next fetch address becomes the loop's first address. Whenever fetch reaches the last address of the innermost loop, the block sends fetch back to the first address in the next cycle. The only exception is the final pass, where fetch falls through to the address after the loop.

There are three kinds of loop. A block loop repeats a range of addresses a counted number of times. A single-word repeat re-issues one address and raises a hold flag, so that the decoder can replay the instruction it already holds instead of fetching it again. An endless loop runs until a break request arrives. Loops nest through a small frame stack. A break request abandons the innermost loop at once.

Top module: `zol_ctrl`

## Requirements
- R1: In reset, and in the first cycle after it, `fetch_addr` equals the RST_ADDR parameter (default 0), and `loop_active`, `hold` and `ovf_err` are low.
- R2: When no loop frame is open and neither a command nor an effective break is present, `fetch_addr` rises by one on every clock.
- R3: A command with `cmd_kind` 0 (block), or the reserved code 3 (handled as block), and a count N of 1 or more sets the next fetch address to `cmd_start`. It then runs the range from `cmd_start` to `cmd_end` N times with no idle cycle at the wrap. After the last pass, fetch moves to `cmd_end`+1. `hold` stays low throughout a block loop.
- R4: A command with `cmd_kind` 1 (single repeat) ignores `cmd_end`. Fetch stays at `cmd_start` for N consecutive cycles and then moves to `cmd_start`+1. `hold` is high in the first N−1 of those cycles and low in the last.
- R5: A block or single-repeat command with count 0 opens no frame. The next fetch address is `cmd_end`+1 for a block and `cmd_start`+1 for a single repeat.
- R6: A command with `cmd_kind` 2 (endless) ignores the count. It wraps from `cmd_end` to `cmd_start` indefinitely until a break request ends it.
- R7: Up to DEPTH (default 4) loops nest. When an inner loop finishes, fetch continues inside the enclosing loop, and that loop keeps its own remaining count.
- R8: A command that would open a frame while DEPTH frames are already open opens none. It sets `ovf_err`, which stays high until reset, and fetch steps by one.
- R9: `brk` with at least one frame open closes the innermost frame, and the next fetch address is that frame's `cmd_end`+1. `brk` with no frame open has no effect beyond ordinary stepping.
- R10: `brk` takes precedence over a command in the same cycle, and the command is then dropped. A command takes precedence over the wrap at a loop's last address.
- R11: `loop_active` is high exactly while at least one loop frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Loop command present this cycle |
| cmd_kind | input | 2 | 0 block, 1 single repeat, 2 endless, 3 treated as block |
| cmd_start | input | AW (24) | First address of the loop body |
| cmd_end | input | AW (24) | Last address of the loop body |
| cmd_count | input | CW (16) | Iteration count, 0 to 65535 |
| brk | input | 1 | Leave the innermost loop now |
| fetch_addr | output | AW (24) | Current fetch address |
| hold | output | 1 | The current instruction is replayed in the next cycle |
| loop_active | output | 1 | At least one loop frame is open |
| ovf_err | output | 1 | Sticky: a loop was started while the stack was full |

## Verification
A wrong stored count surfaces as one wrap too many or too few: fetch moves to the exit address a full body length early or late. This is visible at `fetch_addr` within one body length of the point of error. A wrong stack pointer or frame leaves `loop_active` wrong immediately, and when an inner loop ends, fetch returns to the wrong outer range on the very next cycle. Break and overflow faults show up on `fetch_addr` and `ovf_err` one clock after the request.

// File: rtl/zol_pkg.sv
package zol_pkg;

   typedef enum logic [1:0] {
      LK_BLOCK   = 2'd0,
      LK_SINGLE  = 2'd1,
      LK_ENDLESS = 2'd2,
      LK_RSVD    = 2'd3
   } loop_kind_e;

   // reserved code behaves as a counted block loop
   function automatic loop_kind_e norm_kind(input logic [1:0] raw);
      loop_kind_e k;
      k = loop_kind_e'(raw);
      if (k == LK_RSVD) k = LK_BLOCK;
      return k;
   endfunction

endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
   parameter int DW    = 8,
   parameter int DEPTH = 4,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          upd,
   input  logic [DW-1:0] push_data,
   input  logic [DW-1:0] upd_data,
   output logic [DW-1:0] top_data,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);

   localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

   assign full  = (level == LVL_MAX);
   assign empty = (level == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else if (push && !full) begin
         level <= level + LW'(1);
      end else if (pop && !empty) begin
         level <= level - LW'(1);
      end
   end

   generate
      if (DEPTH == 1) begin : g_one
         logic [DW-1:0] slot;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot <= '0;
            end else if (push && !full) begin
               slot <= push_data;
            end else if (upd && !empty) begin
               slot <= upd_data;
            end
         end
         assign top_data = empty ? '0 : slot;
      end else begin : g_many
         logic [DW-1:0] slot [DEPTH];
         logic [DEPTH-1:0] we_push;
         logic [DEPTH-1:0] we_upd;
         logic [DEPTH-1:0] sel_top;
         for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            assign we_push[i] = push && (level == LW'(i));
            assign we_upd[i]  = upd  && (level == LW'(i + 1));
            assign sel_top[i] = (level == LW'(i + 1));
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
            end else begin
               for (int i = 0; i < DEPTH; i++) begin
                  if (we_push[i]) begin
                     slot[i] <= push_data;
                  end else if (we_upd[i]) begin
                     slot[i] <= upd_data;
                  end
               end
            end
         end
         always_comb begin
            top_data = '0;
            for (int i = 0; i < DEPTH; i++) begin
               if (sel_top[i]) top_data = slot[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/zol_seq.sv
module zol_seq
   import zol_pkg::*;
#(
   parameter int AW = 24,
   parameter int CW = 16
) (
   input  logic [AW-1:0] cur_addr,
   input  logic          cmd_valid,
   input  loop_kind_e    cmd_kind,
   input  logic [AW-1:0] cmd_start,
   input  logic [AW-1:0] cmd_end,
   input  logic [CW-1:0] cmd_count,
   input  logic          brk,
   input  logic          stk_empty,
   input  logic          stk_full,
   input  loop_kind_e    top_kind,
   input  logic [AW-1:0] top_start,
   input  logic [AW-1:0] top_end,
   input  logic [CW-1:0] top_count,
   output logic [AW-1:0] next_addr,
   output logic          push,
   output logic          pop,
   output logic          upd,
   output loop_kind_e    new_kind,
   output logic [AW-1:0] new_start,
   output logic [AW-1:0] new_end,
   output logic [CW-1:0] new_count,
   output logic [CW-1:0] dec_count,
   output logic          hold,
   output logic          ovf_set
);

   logic at_end;
   logic cmd_skip;

   assign at_end    = !stk_empty && (cur_addr == top_end);
   assign new_kind  = cmd_kind;
   assign new_start = cmd_start;
   assign new_end   = (cmd_kind == LK_SINGLE) ? cmd_start : cmd_end;
   assign new_count = cmd_count;
   assign dec_count = top_count - CW'(1);
   assign cmd_skip  = (cmd_kind != LK_ENDLESS) && (cmd_count == '0);

   always_comb begin
      next_addr = cur_addr + AW'(1);
      push      = 1'b0;
      pop       = 1'b0;
      upd       = 1'b0;
      hold      = 1'b0;
      ovf_set   = 1'b0;
      if (brk) begin
         if (!stk_empty) begin
            pop       = 1'b1;
            next_addr = top_end + AW'(1);
         end
      end else if (cmd_valid) begin
         if (cmd_skip) begin
            next_addr = new_end + AW'(1);
         end else if (stk_full) begin
            ovf_set = 1'b1;
         end else begin
            push      = 1'b1;
            next_addr = cmd_start;
         end
      end else if (at_end) begin
         if (top_kind == LK_ENDLESS) begin
            next_addr = top_start;
         end else if (top_count > CW'(1)) begin
            next_addr = top_start;
            upd       = 1'b1;
            hold      = (top_kind == LK_SINGLE);
         end else begin
            pop       = 1'b1;
            next_addr = top_end + AW'(1);
         end
      end
   end

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
   import zol_pkg::*;
#(
   parameter int          AW       = 24,
   parameter int          CW       = 16,
   parameter int          DEPTH    = 4,
   parameter logic [AW-1:0] RST_ADDR = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_kind,
   input  logic [AW-1:0] cmd_start,
   input  logic [AW-1:0] cmd_end,
   input  logic [CW-1:0] cmd_count,
   input  logic          brk,
   output logic [AW-1:0] fetch_addr,
   output logic          hold,
   output logic          loop_active,
   output logic          ovf_err
);

   localparam int FW = 2 + 2 * AW + CW;
   localparam int LW = $clog2(DEPTH + 1);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("zol_ctrl: AW must be at least 2");
      end
      if (CW < 2) begin : g_bad_cw
         $error("zol_ctrl: CW must be at least 2");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("zol_ctrl: DEPTH must be at least 1");
      end
   endgenerate

   logic [AW-1:0] next_addr;
   logic          do_push, do_pop, do_upd, ovf_set;
   logic          stk_full, stk_empty;
   logic [LW-1:0] stk_level;
   logic [FW-1:0] top_data, push_data, upd_data;
   loop_kind_e    top_kind, new_kind;
   logic [AW-1:0] top_start, top_end, new_start, new_end;
   logic [CW-1:0] top_count, new_count, dec_count;

   assign top_kind  = loop_kind_e'(top_data[FW-1 -: 2]);
   assign top_start = top_data[FW-3 -: AW];
   assign top_end   = top_data[CW +: AW];
   assign top_count = top_data[CW-1:0];
   assign push_data = {new_kind, new_start, new_end, new_count};
   assign upd_data  = {top_data[FW-1:CW], dec_count};

   zol_seq #(.AW(AW), .CW(CW)) u_seq (
      .cur_addr  (fetch_addr),
      .cmd_valid (cmd_valid),
      .cmd_kind  (norm_kind(cmd_kind)),
      .cmd_start (cmd_start),
      .cmd_end   (cmd_end),
      .cmd_count (cmd_count),
      .brk       (brk),
      .stk_empty (stk_empty),
      .stk_full  (stk_full),
      .top_kind  (top_kind),
      .top_start (top_start),
      .top_end   (top_end),
      .top_count (top_count),
      .next_addr (next_addr),
      .push      (do_push),
      .pop       (do_pop),
      .upd       (do_upd),
      .new_kind  (new_kind),
      .new_start (new_start),
      .new_end   (new_end),
      .new_count (new_count),
      .dec_count (dec_count),
      .hold      (hold),
      .ovf_set   (ovf_set)
   );

   zol_stack #(.DW(FW), .DEPTH(DEPTH), .LW(LW)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (do_push),
      .pop       (do_pop),
      .upd       (do_upd),
      .push_data (push_data),
      .upd_data  (upd_data),
      .top_data  (top_data),
      .level     (stk_level),
      .full      (stk_full),
      .empty     (stk_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_addr <= RST_ADDR;
         ovf_err    <= 1'b0;
      end else begin
         fetch_addr <= next_addr;
         if (ovf_set) ovf_err <= 1'b1;
      end
   end

   assign loop_active = !stk_empty;

endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
   parameter int AW    = 24,
   parameter int CW    = 16,
   parameter int DEPTH = 4,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [1:0]    cmd_kind,
   input logic [AW-1:0] cmd_end,
   input logic [CW-1:0] cmd_count,
   input logic          brk,
   input logic [AW-1:0] fetch_addr,
   input logic          hold,
   input logic          loop_active,
   input logic          ovf_err,
   input logic [LW-1:0] level,
   input logic [AW-1:0] top_end
);

   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_active && !cmd_valid) |=> fetch_addr == $past(fetch_addr) + AW'(1));

   p_hold_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> fetch_addr == $past(fetch_addr));

   p_hold_in_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> loop_active);

   p_zero_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk && cmd_valid && cmd_kind == 2'd0 && cmd_count == '0)
      |=> fetch_addr == $past(cmd_end) + AW'(1));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);

   p_break_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && loop_active) |=> fetch_addr == $past(top_end) + AW'(1));

   p_endless_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !brk && cmd_kind == 2'd2 && level < LW'(DEPTH)) |=> loop_active);

endmodule

bind zol_ctrl zol_ctrl_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .LW(LW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_kind    (cmd_kind),
   .cmd_end     (cmd_end),
   .cmd_count   (cmd_count),
   .brk         (brk),
   .fetch_addr  (fetch_addr),
   .hold        (hold),
   .loop_active (loop_active),
   .ovf_err     (ovf_err),
   .level       (stk_level),
   .top_end     (top_end)
);

// File: tb/test_zol_ctrl.sv
`timescale 1ns/1ps
module test_zol_ctrl;

   localparam logic [1:0] K_BLK = 2'd0, K_SGL = 2'd1, K_END = 2'd2, K_RSV = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_kind = 2'd0;
   logic [23:0] cmd_start = '0, cmd_end = '0;
   logic [15:0] cmd_count = '0;
   logic        brk = 1'b0;
   logic [23:0] fetch_addr;
   logic        hold, loop_active, ovf_err;

   int n_checks = 0;
   int n_fail = 0;
   logic exp_ovf = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic [23:0] addr;
      logic        act;
      logic        ovf;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   zol_ctrl i_zol_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_count(cmd_count), .brk(brk),
      .fetch_addr(fetch_addr), .hold(hold), .loop_active(loop_active), .ovf_err(ovf_err)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // one cycle: apply inputs, queue post-edge expectation, check hold now
   task automatic cyc(input logic cv, input logic [1:0] k, input logic [23:0] s, input logic [23:0] e,
                      input logic [15:0] n, input logic b, input logic [23:0] ea, input logic eact,
                      input logic ehold, input string tag);
      exp_t it;
      cmd_valid = cv; cmd_kind = k; cmd_start = s; cmd_end = e; cmd_count = n; brk = b;
      it.addr = ea; it.act = eact; it.ovf = exp_ovf; it.tag = tag;
      exp_q.push_back(it);
      #1;
      chk(tag, "hold", {31'd0, hold}, {31'd0, ehold});
      @(negedge clk);
   endtask

   task automatic idle(input logic [23:0] ea, input logic eact, input logic ehold, input string tag);
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b0, ea, eact, ehold, tag);
   endtask

   // monitor: pop and compare after each edge
   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (rst_n && exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            chk(it.tag, "fetch_addr", {8'd0, fetch_addr}, {8'd0, it.addr});
            chk(it.tag, "loop_active", {31'd0, loop_active}, {31'd0, it.act});
            chk(it.tag, "ovf_err", {31'd0, ovf_err}, {31'd0, it.ovf});
         end
      end
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "fetch_addr", {8'd0, fetch_addr}, 32'd0);
      chk("R1", "loop_active", {31'd0, loop_active}, 32'd0);
      chk("R1", "hold", {31'd0, hold}, 32'd0);
      chk("R1", "ovf_err", {31'd0, ovf_err}, 32'd0);
      rst_n = 1'b1;

      // R2 plain stepping
      idle(24'd1, 1'b0, 1'b0, "R2");
      idle(24'd2, 1'b0, 1'b0, "R2");
      idle(24'd3, 1'b0, 1'b0, "R2");

      // R3 counted block loop 10..12, twice
      cyc(1'b1, K_BLK, 24'd10, 24'd12, 16'd2, 1'b0, 24'd10, 1'b1, 1'b0, "R3");
      for (int p = 0; p < 2; p++) begin
         idle(24'd11, 1'b1, 1'b0, "R3");
         idle(24'd12, 1'b1, 1'b0, "R3");
         idle((p == 0) ? 24'd10 : 24'd13, (p == 0), 1'b0, "R3");
      end

      // R4 single repeat at 20, count 3, end ignored
      cyc(1'b1, K_SGL, 24'd20, 24'd99, 16'd3, 1'b0, 24'd20, 1'b1, 1'b0, "R4");
      idle(24'd20, 1'b1, 1'b1, "R4");
      idle(24'd20, 1'b1, 1'b1, "R4");
      idle(24'd21, 1'b0, 1'b0, "R4");

      // R5 zero count skips
      cyc(1'b1, K_BLK, 24'd30, 24'd40, 16'd0, 1'b0, 24'd41, 1'b0, 1'b0, "R5");
      cyc(1'b1, K_SGL, 24'd50, 24'd77, 16'd0, 1'b0, 24'd51, 1'b0, 1'b0, "R5");

      // R6 endless loop 60..61, then break (R9)
      cyc(1'b1, K_END, 24'd60, 24'd61, 16'd0, 1'b0, 24'd60, 1'b1, 1'b0, "R6");
      idle(24'd61, 1'b1, 1'b0, "R6");
      idle(24'd60, 1'b1, 1'b0, "R6");
      idle(24'd61, 1'b1, 1'b0, "R6");
      idle(24'd60, 1'b1, 1'b0, "R6");
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b1, 24'd62, 1'b0, 1'b0, "R9");
      idle(24'd63, 1'b0, 1'b0, "R2");
      // R9 break with no loop open
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b1, 24'd64, 1'b0, 1'b0, "R9");

      // R7 nesting: outer 70..75 x2, inner 72..73 x2 each pass
      cyc(1'b1, K_BLK, 24'd70, 24'd75, 16'd2, 1'b0, 24'd70, 1'b1, 1'b0, "R7");
      idle(24'd71, 1'b1, 1'b0, "R7");
      for (int p = 0; p < 2; p++) begin
         cyc(1'b1, K_BLK, 24'd72, 24'd73, 16'd2, 1'b0, 24'd72, 1'b1, 1'b0, "R7");
         idle(24'd73, 1'b1, 1'b0, "R7");
         idle(24'd72, 1'b1, 1'b0, "R7");
         idle(24'd73, 1'b1, 1'b0, "R7");
         idle(24'd74, 1'b1, 1'b0, "R7");
         idle(24'd75, 1'b1, 1'b0, "R7");
         if (p == 0) begin
            idle(24'd70, 1'b1, 1'b0, "R7");
            idle(24'd71, 1'b1, 1'b0, "R7");
         end else begin
            idle(24'd76, 1'b0, 1'b0, "R7");
         end
      end

      // R8 overflow: four endless frames then a fifth
      for (int f = 0; f < 4; f++) begin
         cyc(1'b1, K_END, 24'(100 + f), 24'(200 - f), 16'd0, 1'b0, 24'(100 + f), 1'b1, 1'b0, "R7");
      end
      exp_ovf = 1'b1;
      cyc(1'b1, K_END, 24'd104, 24'd196, 16'd0, 1'b0, 24'd104, 1'b1, 1'b0, "R8");
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b1, 24'd198, 1'b1, 1'b0, "R9");
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b1, 24'd199, 1'b1, 1'b0, "R9");
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b1, 24'd200, 1'b1, 1'b0, "R9");
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b1, 24'd201, 1'b0, 1'b0, "R11");

      // R10 break beats a command at a loop end
      cyc(1'b1, K_BLK, 24'd210, 24'd211, 16'd2, 1'b0, 24'd210, 1'b1, 1'b0, "R10");
      idle(24'd211, 1'b1, 1'b0, "R10");
      cyc(1'b1, K_BLK, 24'd250, 24'd251, 16'd5, 1'b1, 24'd212, 1'b0, 1'b0, "R10");
      idle(24'd213, 1'b0, 1'b0, "R10");
      // R10 command beats the wrap at a loop end
      cyc(1'b1, K_BLK, 24'd220, 24'd221, 16'd3, 1'b0, 24'd220, 1'b1, 1'b0, "R10");
      idle(24'd221, 1'b1, 1'b0, "R10");
      cyc(1'b1, K_BLK, 24'd230, 24'd230, 16'd1, 1'b0, 24'd230, 1'b1, 1'b0, "R10");
      idle(24'd231, 1'b1, 1'b0, "R10");
      cyc(1'b0, K_BLK, '0, '0, '0, 1'b1, 24'd222, 1'b0, 1'b0, "R10");

      // R3 reserved kind code behaves as a block loop (no hold)
      cyc(1'b1, K_RSV, 24'd240, 24'd240, 16'd2, 1'b0, 24'd240, 1'b1, 1'b0, "R3");
      idle(24'd240, 1'b1, 1'b0, "R3");
      idle(24'd241, 1'b0, 1'b0, "R3");

      @(posedge clk);
      #5;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule